// File: doc/BRIEF.md
# ADC Result Format Converter

This block takes the raw unsigned code of an analog-to-digital conversion and turns it into a 16-bit word in one of four number formats. It handles a short code and a long code. A resolution mode input selects between them, and with the default parameters that means 10 or 12 bits. A 2-bit format select picks one of four layouts: unsigned integer, signed integer, unsigned fraction or signed fraction.

The two signed layouts turn the converter's offset-binary code into two's complement. They do this by inverting the code's top bit. The two fractional layouts left-justify the code so that its weight matches a Q15-style fraction. A single-cycle valid pulse loads the formatted word into an output register and raises an output-valid flag. Both then hold until the next pulse.

Top module: `adc_fmt_conv`

## Requirements
- R1: With fmt_sel = 2'b00 the output is the code right-justified, with every bit above the code set to zero.
- R2: With fmt_sel = 2'b01 the output is the code with its top bit inverted and that inverted bit copied into every output bit above the remaining code bits. This equals the code minus half scale, sign-extended to 16 bits.
- R3: With fmt_sel = 2'b10 the output is the code left-justified to bit 15, with zeros below it.
- R4: With fmt_sel = 2'b11 the output is left-justified. Bit 15 is the inverted code top bit, followed by the remaining code bits, with zeros below. This equals (code minus half scale) shifted to the top of the word.
- R5: With res_hi = 0 the block uses only code_in[9:0] and ignores code_in[11:10]. The fractional formats then leave six zero LSBs, and the signed integer format has seven sign bits above nine data bits.
- R6: With res_hi = 1 the block uses code_in[11:0]. The fractional formats then leave four zero LSBs, and the signed integer format has five sign bits above eleven data bits.
- R7: word_out takes the formatted value of the inputs sampled on a clock edge where code_vld = 1, and shows it after that edge. On edges where code_vld = 0, word_out does not change, whatever the other inputs do.
- R8: A synchronous reset (rst = 1 on a clock edge) clears word_out to zero and word_vld to 0.
- R9: word_vld goes to 1 on the edge that samples code_vld = 1, and it stays at 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_hi | input | 1 | Resolution mode: 1 = 12-bit code, 0 = 10-bit code |
| fmt_sel | input | 2 | Output format select (00 uint, 01 sint, 10 ufrac, 11 sfrac) |
| code_in | input | 12 | Raw unsigned conversion code |
| code_vld | input | 1 | One-cycle pulse: format and register code_in |
| word_out | output | 16 | Registered formatted result |
| word_vld | output | 1 | Set once a result has been registered since reset |

## Verification
The bench starts with directed corner cases at both resolutions:
- Code zero and full scale. These separate the sign inversion from plain sign-extension.
- The two codes either side of half scale. These expose an off-by-one in the sign-bit position.

After that, the bench drives several hundred random codes with random formats and resolutions from a fixed seed. In 10-bit mode the upper code bits carry random junk, which shows whether those bits leak into the result. Between pulses the bench changes the inputs while code_vld stays low, which separates a held register from one that follows its inputs. A reset in the middle of the run confirms that the output clears and the valid flag stays low until the next pulse.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
   typedef enum logic [1:0] {
      FMT_UINT  = 2'b00,
      FMT_SINT  = 2'b01,
      FMT_UFRAC = 2'b10,
      FMT_SFRAC = 2'b11
   } fmt_e;
endpackage

// File: rtl/adc_fmt_justify.sv
module adc_fmt_justify
   import adc_fmt_pkg::*;
#(
   parameter int CODE_W = 10,
   parameter int OUT_W  = 16
) (
   input  logic [CODE_W-1:0] code,
   input  fmt_e              fmt,
   output logic [OUT_W-1:0]  word
);
   localparam int PAD_W = OUT_W - CODE_W;

   if (CODE_W < 2) begin : g_chk_code
      $error("adc_fmt_justify: CODE_W must be at least 2");
   end
   if (PAD_W < 1) begin : g_chk_pad
      $error("adc_fmt_justify: OUT_W must exceed CODE_W");
   end

   logic                sign_bit;
   logic [CODE_W-2:0]   body;

   assign sign_bit = ~code[CODE_W-1];
   assign body     = code[CODE_W-2:0];

   always_comb begin
      unique case (fmt)
         FMT_UINT:  word = {{PAD_W{1'b0}}, code};
         FMT_SINT:  word = {{(PAD_W+1){sign_bit}}, body};
         FMT_UFRAC: word = {code, {PAD_W{1'b0}}};
         FMT_SFRAC: word = {sign_bit, body, {PAD_W{1'b0}}};
         default:   word = '0;
      endcase
   end
endmodule

// File: rtl/adc_fmt_outreg.sv
module adc_fmt_outreg #(
   parameter int OUT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [OUT_W-1:0] d,
   output logic [OUT_W-1:0] q,
   output logic             vld
);
   if (OUT_W < 1) begin : g_chk_w
      $error("adc_fmt_outreg: OUT_W must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q   <= '0;
         vld <= 1'b0;
      end else if (load) begin
         q   <= d;
         vld <= 1'b1;
      end
   end

   AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (q == '0 && !vld)); // R8
   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
      load |=> (vld && q == $past(d))); // R7
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !load |=> ($stable(q) && $stable(vld))); // R9
endmodule

// File: rtl/adc_fmt_conv.sv
module adc_fmt_conv
   import adc_fmt_pkg::*;
#(
   parameter int LO_W  = 10,
   parameter int HI_W  = 12,
   parameter int OUT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             res_hi,
   input  logic [1:0]       fmt_sel,
   input  logic [HI_W-1:0]  code_in,
   input  logic             code_vld,
   output logic [OUT_W-1:0] word_out,
   output logic             word_vld
);
   localparam int N_RES    = 2;
   localparam int LO_PAD   = OUT_W - LO_W;
   localparam int HI_PAD   = OUT_W - HI_W;

   if (LO_W >= HI_W) begin : g_chk_res
      $error("adc_fmt_conv: LO_W must be below HI_W");
   end
   if (HI_W >= OUT_W) begin : g_chk_out
      $error("adc_fmt_conv: HI_W must be below OUT_W");
   end

   fmt_e                          fmt;
   logic [N_RES-1:0][OUT_W-1:0]   cand;
   logic [OUT_W-1:0]              next_word;

   assign fmt = fmt_e'(fmt_sel);

   for (genvar g = 0; g < N_RES; g++) begin : g_res
      localparam int W = (g == 0) ? LO_W : HI_W;
      adc_fmt_justify #(
         .CODE_W (W),
         .OUT_W  (OUT_W)
      ) u_just (
         .code (code_in[W-1:0]),
         .fmt  (fmt),
         .word (cand[g])
      );
   end

   assign next_word = res_hi ? cand[1] : cand[0];

   adc_fmt_outreg #(
      .OUT_W (OUT_W)
   ) u_oreg (
      .clk  (clk),
      .rst  (rst),
      .load (code_vld),
      .d    (next_word),
      .q    (word_out),
      .vld  (word_vld)
   );

   AST_UINT_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
      (code_vld && fmt_sel == 2'b00 && res_hi) |=> (word_out[OUT_W-1:HI_W] == '0)); // R1
   AST_SINT_EXT_LO: assert property (@(posedge clk) disable iff (rst)
      (code_vld && fmt_sel == 2'b01 && !res_hi) |=>
      (word_out[OUT_W-1:LO_W-1] == {(LO_PAD+1){~$past(code_in[LO_W-1])}})); // R2
   AST_UFRAC_TOP_HI: assert property (@(posedge clk) disable iff (rst)
      (code_vld && fmt_sel == 2'b10 && res_hi) |=>
      (word_out[OUT_W-1:HI_PAD] == $past(code_in))); // R3
   AST_SFRAC_SIGN: assert property (@(posedge clk) disable iff (rst)
      (code_vld && fmt_sel == 2'b11 && res_hi) |=>
      (word_out[OUT_W-1] != $past(code_in[HI_W-1]))); // R4
   AST_FRAC_PAD_LO: assert property (@(posedge clk) disable iff (rst)
      (code_vld && fmt_sel[1] && !res_hi) |=> (word_out[LO_PAD-1:0] == '0)); // R5
   AST_FRAC_PAD_HI: assert property (@(posedge clk) disable iff (rst)
      (code_vld && fmt_sel[1] && res_hi) |=> (word_out[HI_PAD-1:0] == '0)); // R6
endmodule

// File: tb/adc_fmt_conv_tb.sv
module adc_fmt_conv_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        res_hi;
   logic [1:0]  fmt_sel;
   logic [11:0] code_in;
   logic        code_vld;
   logic [15:0] word_out;
   logic        word_vld;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_fmt_conv u_dut (
      .clk      (clk),
      .rst      (rst),
      .res_hi   (res_hi),
      .fmt_sel  (fmt_sel),
      .code_in  (code_in),
      .code_vld (code_vld),
      .word_out (word_out),
      .word_vld (word_vld)
   );

   function automatic logic [15:0] model(bit hi, bit [1:0] f, bit [11:0] c);
      int w;
      int v;
      int s;
      w = hi ? 12 : 10;
      v = hi ? int'(c) : int'(c & 12'h3FF);
      s = v - (1 << (w - 1));
      case (f)
         2'b00:   return 16'(v);
         2'b01:   return 16'(s);
         2'b10:   return 16'(v << (16 - w));
         default: return 16'(s << (16 - w));
      endcase
   endfunction

   function automatic string fmt_tag(bit [1:0] f);
      case (f)
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // Drive one conversion result, then check the registered word and the hold behaviour.
   task automatic apply(bit hi, bit [1:0] f, bit [11:0] c);
      logic [15:0] exp;
      string rtag;
      exp  = model(hi, f, c);
      rtag = hi ? "R6" : "R5";
      @(negedge clk);
      res_hi = hi; fmt_sel = f; code_in = c; code_vld = 1'b1;
      @(negedge clk);
      code_vld = 1'b0;
      check({fmt_tag(f), "/", rtag}, word_out, exp);
      check("R9 vld", {15'd0, word_vld}, 16'd1);
      // R7: scramble the inputs without a pulse; the output must hold
      res_hi = ~hi; fmt_sel = ~f; code_in = ~c;
      @(negedge clk);
      check("R7 hold", word_out, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd7731));
      rst = 1'b1; res_hi = 1'b0; fmt_sel = 2'b00; code_in = '0; code_vld = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R8: reset state
      check("R8 word", word_out, 16'h0000);
      check("R8 vld", {15'd0, word_vld}, 16'd0);

      // Directed corners at both resolutions and all formats
      for (int hi = 0; hi < 2; hi++) begin
         for (int f = 0; f < 4; f++) begin
            apply(bit'(hi), 2'(f), 12'h000);
            apply(bit'(hi), 2'(f), hi ? 12'hFFF : 12'h3FF);
            apply(bit'(hi), 2'(f), hi ? 12'h800 : 12'h200);
            apply(bit'(hi), 2'(f), hi ? 12'h7FF : 12'h1FF);
         end
      end

      // R5: upper code bits set in 10-bit mode must not leak into the result
      apply(1'b0, 2'b00, 12'hC05);
      apply(1'b0, 2'b11, 12'hE00);

      // R8: reset mid-run clears output and flag
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R8 mid word", word_out, 16'h0000);
      check("R8 mid vld", {15'd0, word_vld}, 16'd0);
      @(negedge clk);
      check("R9 stays low", {15'd0, word_vld}, 16'd0);

      // Random stimulus
      for (int i = 0; i < 400; i++) begin
         apply(bit'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 12'($urandom));
      end

      done = 1'b1;
      finish_run();
   end
endmodule